// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This engine walks a circular list of transmit descriptors kept in a word-addressed memory and turns each one into a byte stream. Each descriptor takes four 32-bit words: control, length, buffer address and one spare word. Software fills a descriptor and sets its ownership bit, then pulses the start request. The engine fetches the descriptor and reads the buffer word by word. It sends the bytes out on a valid/ready/last stream and writes the control word back with ownership returned to software.

The engine follows its own pointer through the ring. A descriptor that carries the end-of-list flag sends the pointer back to the ring base. When the engine fetches a control word that software still owns, it goes idle and leaves the pointer on that descriptor. The next request resumes there. Frame formatting, padding, checksums and interrupts are outside the block.

Top module: `txr_dma`

## Requirements
- R1: After reset `running` and `tx_valid` are 0, no memory access is made and `frame_done` is 0.
- R2: A `kick` pulse while idle sets `running`, and in the next cycle the engine reads the control word of the current descriptor. The first kick after reset takes the descriptor at `ring_base` (a byte address; word address `ring_base>>2`). A kick while running has no effect.
- R3: A descriptor at word address D uses the following words. Word D is control: bit 31 owned-by-engine, bit 30 end-of-list, bit 29 frame start, bit 28 frame end. Bits 31:16 of word D+1 hold the byte count. Word D+2 holds the 4-byte-aligned byte address of the buffer.
- R4: The stream carries exactly the byte count of the buffer, in rising address order. Each memory word is split into bytes least significant byte first.
- R5: `tx_last` is 1 on the final byte of a descriptor whose frame-end bit (28) is set, and 0 on every other byte.
- R6: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid`, `tx_data` and `tx_last` hold their values into the next cycle.
- R7: After the final byte is accepted, the engine writes the control word back to word D with bit 31 cleared and every other bit unchanged.
- R8: `frame_done` pulses for one cycle, together with the write-back, for every descriptor whose bit 28 is set.
- R9: After the write-back the next descriptor is at D+4 (16 bytes on). If bit 30 was set, it is at `ring_base>>2` instead.
- R10: If a fetched control word has bit 31 clear, `running` drops and nothing is written. The pointer stays on that descriptor, so the next kick reads it again.
- R11: A byte count of 0 emits no byte but still writes the descriptor back, and still pulses `frame_done` when bit 28 is set.
- R12: The memory port never reads and writes in the same cycle. A read returns `mem_rdata` one cycle after `mem_rd`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_base | input | AW+2 | Byte address of the first descriptor |
| kick | input | 1 | Start request strobe |
| mem_rd | output | 1 | Memory read request |
| mem_we | output | 1 | Memory write request |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after `mem_rd` |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of a frame |
| tx_ready | input | 1 | Stream sink ready |
| running | output | 1 | Engine is walking the ring |
| frame_done | output | 1 | One-cycle pulse when a frame-end descriptor is retired |

## Verification
The bench builds the engine with AW=8, a 256-word memory, and places a three-descriptor ring at byte address 0x40. This small map makes the end-of-list wrap and the stop-on-unowned-descriptor case happen within a few hundred cycles. The bench also resumes from a descriptor in the middle of the ring. Byte counts of 0, 3, 4, 5, 6 and 7 cover a partial last word, an exact word and a two-word buffer. Three ready patterns (always ready, two of three cycles, alternate cycles) exercise stalls at every byte lane.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int ACT_BIT    = 31;
  localparam int EOL_BIT    = 30;
  localparam int FSTART_BIT = 29;
  localparam int FEND_BIT   = 28;
  localparam int W_CTL       = 0;
  localparam int W_LEN       = 1;
  localparam int W_BUF       = 2;
  localparam int DESC_STRIDE = 4;
  localparam int CNT_W       = 16;

  typedef enum logic [3:0] {
    S_IDLE, S_CTL_RD, S_CTL_WT, S_LEN_RD, S_LEN_WT, S_BUF_RD, S_BUF_WT,
    S_DAT_RD, S_DAT_WT, S_DAT_OUT, S_WBACK
  } txr_state_e;

  function automatic logic [CNT_W-1:0] count_field(input logic [31:0] w);
    return w[31:32-CNT_W];
  endfunction

  function automatic logic [31:0] retire_ctl(input logic [31:0] c);
    logic [31:0] r;
    r = c;
    r[ACT_BIT] = 1'b0;
    return r;
  endfunction

  function automatic logic [7:0] lane_of(input logic [31:0] w, input logic [1:0] i);
    return w[8*i +: 8];
  endfunction
endpackage

// File: rtl/txr_ring_ptr.sv
module txr_ring_ptr
  import txr_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          advance,
  input  logic          wrap,
  input  logic [AW-1:0] base_w,
  output logic [AW-1:0] ptr_w
);
  logic fresh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fresh <= 1'b1;
      ptr_w <= '0;
    end else if (start && fresh) begin
      fresh <= 1'b0;
      ptr_w <= base_w;
    end else if (advance) begin
      ptr_w <= wrap ? base_w : ptr_w + AW'(DESC_STRIDE);
    end
  end

  // R9: a pointer move lands on a descriptor-aligned word when the base is aligned
  a_r9_aligned_step: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !wrap && ptr_w[1:0] == 2'b00) |=> ptr_w[1:0] == 2'b00);
endmodule

// File: rtl/txr_byte_pump.sv
module txr_byte_pump
  import txr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_len,
  input  logic [CNT_W-1:0] len_in,
  input  logic             load_word,
  input  logic [31:0]      word_in,
  input  logic             active,
  input  logic             ready,
  input  logic             frag_end,
  output logic [7:0]       lane,
  output logic             last,
  output logic             len_zero,
  output logic             final_beat,
  output logic             word_end
);
  logic [CNT_W-1:0] remain;
  logic [1:0]       idx;
  logic [31:0]      word_q;
  logic             accept;

  assign accept     = active && ready;
  assign lane       = lane_of(word_q, idx);
  assign len_zero   = (remain == '0);
  assign last       = active && frag_end && (remain == CNT_W'(1));
  assign final_beat = accept && (remain == CNT_W'(1));
  assign word_end   = accept && (idx == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
      idx    <= '0;
      word_q <= '0;
    end else begin
      if (load_len) begin
        remain <= len_in;
        idx    <= '0;
      end else if (accept) begin
        remain <= remain - CNT_W'(1);
        idx    <= idx + 2'd1;
      end
      if (load_word) word_q <= word_in;
    end
  end

  // R6: a stalled byte stays put
  a_r6_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !ready) |=> (active && $stable(lane) && $stable(last)));
  // R4: never offer a byte beyond the programmed count
  a_r4_no_underrun: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> !len_zero);
endmodule

// File: rtl/txr_dma.sv
module txr_dma
  import txr_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW+1:0] ring_base,
  input  logic          kick,
  output logic          mem_rd,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  input  logic          tx_ready,
  output logic          running,
  output logic          frame_done
);
  txr_state_e    state;
  logic [31:0]   ctl_q;
  logic [AW-1:0] buf_w;
  logic [AW-1:0] ptr_w;
  logic [AW-1:0] base_w;
  logic          start_evt, retire_evt, stop_evt;
  logic          len_zero, final_beat, word_end;
  logic [3:0]    unused_bits;

  assign base_w      = ring_base[AW+1:2];
  assign unused_bits = {ring_base[1:0], mem_rdata[1:0]};
  assign start_evt   = (state == S_IDLE) && kick;
  assign retire_evt  = (state == S_WBACK);
  assign stop_evt    = (state == S_CTL_WT) && !mem_rdata[ACT_BIT];

  txr_ring_ptr #(.AW(AW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .start(start_evt), .advance(retire_evt),
    .wrap(ctl_q[EOL_BIT]), .base_w(base_w), .ptr_w(ptr_w)
  );

  txr_byte_pump u_pump (
    .clk(clk), .rst_n(rst_n),
    .load_len(state == S_LEN_WT), .len_in(count_field(mem_rdata)),
    .load_word(state == S_DAT_WT), .word_in(mem_rdata),
    .active(state == S_DAT_OUT), .ready(tx_ready), .frag_end(ctl_q[FEND_BIT]),
    .lane(tx_data), .last(tx_last), .len_zero(len_zero),
    .final_beat(final_beat), .word_end(word_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      ctl_q   <= '0;
      buf_w   <= '0;
      running <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (kick) begin
          state   <= S_CTL_RD;
          running <= 1'b1;
        end
        S_CTL_RD: state <= S_CTL_WT;
        S_CTL_WT: begin
          ctl_q <= mem_rdata;
          if (stop_evt) begin
            state   <= S_IDLE;
            running <= 1'b0;
          end else begin
            state <= S_LEN_RD;
          end
        end
        S_LEN_RD: state <= S_LEN_WT;
        S_LEN_WT: state <= S_BUF_RD;
        S_BUF_RD: state <= S_BUF_WT;
        S_BUF_WT: begin
          buf_w <= mem_rdata[AW+1:2];
          state <= len_zero ? S_WBACK : S_DAT_RD;
        end
        S_DAT_RD: begin
          buf_w <= buf_w + AW'(1);
          state <= S_DAT_WT;
        end
        S_DAT_WT: state <= S_DAT_OUT;
        S_DAT_OUT: begin
          if (final_beat)    state <= S_WBACK;
          else if (word_end) state <= S_DAT_RD;
        end
        S_WBACK: state <= S_CTL_RD;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_rd   = 1'b0;
    mem_addr = ptr_w + AW'(W_CTL);
    unique case (state)
      S_CTL_RD: mem_rd = 1'b1;
      S_LEN_RD: begin mem_rd = 1'b1; mem_addr = ptr_w + AW'(W_LEN); end
      S_BUF_RD: begin mem_rd = 1'b1; mem_addr = ptr_w + AW'(W_BUF); end
      S_DAT_RD: begin mem_rd = 1'b1; mem_addr = buf_w; end
      default: ;
    endcase
  end

  assign mem_we     = retire_evt;
  assign mem_wdata  = retire_ctl(ctl_q);
  assign tx_valid   = (state == S_DAT_OUT);
  assign frame_done = retire_evt && ctl_q[FEND_BIT];

  // R12: one port, one operation per cycle
  a_r12_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_we));
  // R10: an idle engine leaves memory and stream alone
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (!mem_rd && !mem_we && !tx_valid && !frame_done));
  // R2: the first cycle of a run is a control-word fetch
  a_r2_first_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> mem_rd);
  // R7: a write-back is followed by the next fetch, never a byte
  a_r7_wb_then_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (mem_rd && !tx_valid));
endmodule

// File: tb/test_txr_dma.sv
`timescale 1ns/1ps
module test_txr_dma;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW+1:0] ring_base = 10'h040;
  logic          kick = 1'b0;
  logic          mem_rd, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata;
  logic [31:0]   mem_rdata = '0;
  logic          tx_valid, tx_last, running, frame_done;
  logic [7:0]    tx_data;
  logic          tx_ready = 1'b1;

  logic [31:0] mem [0:(1<<AW)-1];
  int checks = 0, fails = 0, cyc = 0, ready_mode = 0;
  int fd_count = 0, fd_expect = 0;
  logic [8:0]  exp_b [$];
  int          exp_wa [$];
  logic [31:0] exp_wd [$];
  bit          exp_wf [$];
  bit          stall_prev = 0;
  logic [8:0]  held_prev = '0;

  always #4 clk = ~clk;

  txr_dma #(.AW(AW)) i_txr_dma (
    .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .kick(kick),
    .mem_rd(mem_rd), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .tx_ready(tx_ready), .running(running), .frame_done(frame_done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (mem_we) mem[mem_addr] <= mem_wdata;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      chk(0, "watchdog", cyc, 100000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // reference comparison on every clock
  always @(negedge clk) begin
    case (ready_mode)
      1: tx_ready = (cyc % 3) != 0;
      2: tx_ready = cyc[0];
      default: tx_ready = 1'b1;
    endcase
    #1;
    if (rst_n) begin
      if (stall_prev)
        chk(tx_valid && {tx_last, tx_data} == held_prev, "R6 stall hold", {tx_valid, tx_last, tx_data}, {1'b1, held_prev});
      if (tx_valid && tx_ready) begin
        if (exp_b.size() == 0) chk(0, "R4 unexpected byte", tx_data, 0);
        else begin
          logic [8:0] e;
          e = exp_b.pop_front();
          chk(tx_data == e[7:0], "R4 byte", tx_data, e[7:0]);
          chk(tx_last == e[8], "R5 last", tx_last, e[8]);
        end
      end
      stall_prev = tx_valid && !tx_ready;
      held_prev  = {tx_last, tx_data};
      if (mem_we) begin
        if (exp_wa.size() == 0) chk(0, "R7 unexpected write", mem_addr, 0);
        else begin
          int a; logic [31:0] d; bit f;
          a = exp_wa.pop_front(); d = exp_wd.pop_front(); f = exp_wf.pop_front();
          chk(mem_addr == AW'(a), "R7 write address", mem_addr, a);
          chk(mem_wdata == d, "R7 write data", mem_wdata, d);
          chk(frame_done == f, "R8 frame_done with write", frame_done, f);
        end
      end
      if (mem_rd && mem_we) chk(0, "R12 read and write together", 1, 0);
      if (frame_done) fd_count++;
    end
  end

  task automatic arm(input int dw, input logic [31:0] c, input int len, input logic [31:0] ba);
    mem[dw]     <= c;
    mem[dw + 1] <= {16'(len), 16'h0000};
    mem[dw + 2] <= ba;
    mem[dw + 3] <= 32'h0;
  endtask

  // expectation from the stated layout: little-endian bytes, count in bits 31:16
  task automatic expect_desc(input int dw);
    logic [31:0] c; int len; int ba;
    c = mem[dw]; len = int'(mem[dw + 1] >> 16); ba = int'(mem[dw + 2]);
    for (int i = 0; i < len; i++) begin
      int a; logic [31:0] w;
      a = ba + i;
      w = mem[a / 4] >> (8 * (a % 4));
      exp_b.push_back({(i == len - 1) && c[28], w[7:0]});
    end
    exp_wa.push_back(dw);
    exp_wd.push_back(c & 32'h7fff_ffff);
    exp_wf.push_back(c[28]);
    if (c[28]) fd_expect++;
  endtask

  task automatic kick_and_check(input int dw, input string req);
    @(negedge clk); kick = 1'b1;
    @(negedge clk); kick = 1'b0;
    #2;
    chk(mem_rd && running, {req, " fetch starts"}, {mem_rd, running}, 2'b11);
    chk(mem_addr == AW'(dw), {req, " fetch address"}, mem_addr, dw);
  endtask

  task automatic wait_stop(input string req);
    int n = 0;
    do begin @(negedge clk); n++; end while (running && n < 5000);
    #2;
    chk(!running, {req, " engine stopped"}, running, 0);
    chk(exp_b.size() == 0 && exp_wa.size() == 0, {req, " all expected traffic seen"}, exp_b.size() + exp_wa.size(), 0);
    chk(fd_count == fd_expect, "R8 frame_done count", fd_count, fd_expect);
  endtask

  initial begin
    for (int w = 0; w < (1 << AW); w++) mem[w] = 32'h0;
    for (int w = 64; w < 160; w++)
      mem[w] = {8'(4*w+3) ^ 8'h5A, 8'(4*w+2) ^ 8'h5A, 8'(4*w+1) ^ 8'h5A, 8'(4*w) ^ 8'h5A};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk(!running && !tx_valid && !mem_rd && !mem_we && !frame_done, "R1 reset state",
        {running, tx_valid, mem_rd, mem_we, frame_done}, 0);

    // ring: words 16, 20, 24 (byte 0x40, 0x50, 0x60)
    arm(16, 32'hB000_0000, 5, 32'h100);
    arm(20, 32'hA000_0000, 4, 32'h180);
    arm(24, 32'hD000_0000, 3, 32'h200);
    @(negedge clk);
    expect_desc(16); expect_desc(20); expect_desc(24);
    ready_mode = 1;
    kick_and_check(16, "R2");
    wait_stop("R3");
    chk(mem[16] == 32'h3000_0000, "R7 active cleared", mem[16], 32'h3000_0000);
    chk(mem[24] == 32'h5000_0000, "R7 end-of-list kept", mem[24], 32'h5000_0000);

    // resumes at word 16 after wrap: zero length then a 7-byte frame
    arm(16, 32'hB000_0000, 0, 32'h100);
    arm(20, 32'hB000_0000, 7, 32'h180);
    @(negedge clk);
    expect_desc(16); expect_desc(20);
    ready_mode = 0;
    kick_and_check(16, "R9 wrap");
    repeat (4) @(negedge clk);
    kick = 1'b1; @(negedge clk); kick = 1'b0;
    wait_stop("R2 kick while running");
    chk(mem[16] == 32'h3000_0000, "R11 zero length retired", mem[16], 32'h3000_0000);
    chk(mem[24] == 32'h5000_0000, "R10 unowned not written", mem[24], 32'h5000_0000);

    // resume at the descriptor where the engine stopped
    arm(24, 32'hD000_0000, 6, 32'h200);
    @(negedge clk);
    expect_desc(24);
    ready_mode = 2;
    kick_and_check(24, "R10 resume");
    wait_stop("R9");
    chk(mem[24] == 32'h5000_0000, "R7 final write-back", mem[24], 32'h5000_0000);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule